// File: doc/BRIEF.md
# SMBus Bus Timeout Detector

This block watches the already filtered SCL and SDA samples of an SMBus port. It runs on the peripheral kernel clock and reports two kinds of bus fault through sticky flags. Software clears each flag with a one-cycle strobe.

The first timer, A, has two modes chosen by a mode bit:
- **Low mode:** it measures how long SCL stays low without a break.
- **Idle mode:** it measures how long SCL and SDA are both high.

A low run is counted in units of 2^LONG_LOG2 kernel cycles, 2048 by default. An idle run is counted in units of 2^SHORT_LOG2 cycles, 4 by default.

The second timer, B, adds up the cycles in which this node itself holds SCL low. The sum covers one frame and restarts at every START or STOP. A single limit field serves the slave and the master extension budget, so the block needs no role input.

Each timer has its own enable. While a timer is enabled, its limit field, and for timer A also the mode bit, cannot be written. The protocol engine drives the stretch indication and the frame-edge pulse. Software drives the configuration writes, the enables and the clear strobes.

Top module: `smbus_timeout_mon`

## Requirements
- R1: After reset both flags are 0, both limits read 0 and the idle-mode readback is 0 (low mode).
- R2: In low mode (idle_mode = 0) with tmo_en = 1, tmo_flag becomes 1 on the clock edge at which SCL has been 0 for more than (lim_a+1)×2^LONG_LOG2 consecutive cycles, and not before.
- R3: In idle mode (idle_mode = 1) with tmo_en = 1, tmo_flag becomes 1 on the edge at which SCL and SDA have both been 1 for more than (lim_a+1)×2^SHORT_LOG2 consecutive cycles, and not before.
- R4: A single cycle in which timer A's condition is false restarts its count from zero.
- R5: With ext_en = 1, ext_flag becomes 1 once the total number of cycles with self_stretch = 1 and SCL = 0 exceeds (lim_b+1)×2^LONG_LOG2. Cycles outside that condition neither add to the total nor clear it.
- R6: A cycle with frame_edge = 1 clears timer B's total, and no ext_flag is raised in that cycle.
- R7: When cfg_a_wr = 1 the values cfg_a_val and cfg_idle_sel are stored, but only while tmo_en = 0. When cfg_b_wr = 1 the value cfg_b_val is stored, but only while ext_en = 0. The stored values appear on lim_a, idle_mode and lim_b on the next cycle.
- R8: Each flag stays at 1 until its clear strobe. The clear takes priority over a new set and restarts that timer's count.
- R9: While a timer's enable is 0, its count is held at zero and its flag cannot go from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sampled SCL level |
| sda_in | input | 1 | Sampled SDA level |
| self_stretch | input | 1 | This node is driving SCL low |
| frame_edge | input | 1 | One-cycle pulse at START or STOP |
| cfg_a_wr | input | 1 | Write strobe for timer A limit and mode |
| cfg_a_val | input | VAL_W | New timer A limit |
| cfg_idle_sel | input | 1 | New timer A mode: 0 low, 1 idle |
| cfg_b_wr | input | 1 | Write strobe for timer B limit |
| cfg_b_val | input | VAL_W | New timer B limit |
| tmo_en | input | 1 | Timer A enable |
| ext_en | input | 1 | Timer B enable |
| tmo_clr | input | 1 | Clear strobe for tmo_flag |
| ext_clr | input | 1 | Clear strobe for ext_flag |
| tmo_flag | output | 1 | Sticky timer A fault |
| ext_flag | output | 1 | Sticky timer B fault |
| lim_a | output | VAL_W | Stored timer A limit |
| idle_mode | output | 1 | Stored timer A mode |
| lim_b | output | VAL_W | Stored timer B limit |

## Verification
The bench builds the block with VAL_W = 4, LONG_LOG2 = 4 and SHORT_LOG2 = 2. A long-unit threshold is then at most 256 cycles and an idle threshold at most 64 cycles. This lets random SCL/SDA runs cross every limit value many times, including the saturation of the tick counter at the top limit. Because the default SHORT_LOG2 is kept, idle mode is exercised at its real ×4 granularity. The smaller LONG_LOG2 shows that the ×2048 path works through the same prescaler boundary, just earlier.

// File: rtl/smbus_timeout_mon.sv
module smbus_timeout_mon #(
  parameter int VAL_W      = 12,
  parameter int LONG_LOG2  = 11,
  parameter int SHORT_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             self_stretch,
  input  logic             frame_edge,
  input  logic             cfg_a_wr,
  input  logic [VAL_W-1:0] cfg_a_val,
  input  logic             cfg_idle_sel,
  input  logic             cfg_b_wr,
  input  logic [VAL_W-1:0] cfg_b_val,
  input  logic             tmo_en,
  input  logic             ext_en,
  input  logic             tmo_clr,
  input  logic             ext_clr,
  output logic             tmo_flag,
  output logic             ext_flag,
  output logic [VAL_W-1:0] lim_a,
  output logic             idle_mode,
  output logic [VAL_W-1:0] lim_b
);

  localparam int PW = LONG_LOG2;
  localparam int CW = VAL_W + 1;
  localparam logic [PW-1:0] LONG_TOP  = '1;
  localparam logic [PW-1:0] SHORT_TOP = PW'((1 << SHORT_LOG2) - 1);

  // configuration, locked while the owning timer runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_a     <= '0;
      idle_mode <= 1'b0;
      lim_b     <= '0;
    end else begin
      if (cfg_a_wr && !tmo_en) begin
        lim_a     <= cfg_a_val;
        idle_mode <= cfg_idle_sel;
      end
      if (cfg_b_wr && !ext_en) lim_b <= cfg_b_val;
    end
  end

  // timer A: SCL low run or bus idle run
  logic [PW-1:0] pre_a;
  logic [CW-1:0] ticks_a;
  wire           cond_a = idle_mode ? (scl_in & sda_in) : ~scl_in;
  wire  [PW-1:0] top_a  = idle_mode ? SHORT_TOP : LONG_TOP;
  wire           hit_a  = ticks_a == CW'(lim_a) + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_a   <= '0;
      ticks_a <= '0;
    end else if (!tmo_en || tmo_clr || !cond_a) begin
      pre_a   <= '0;
      ticks_a <= '0;
    end else if (!hit_a) begin
      if (pre_a == top_a) begin
        pre_a   <= '0;
        ticks_a <= ticks_a + CW'(1);
      end else begin
        pre_a <= pre_a + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tmo_flag <= 1'b0;
    else if (tmo_clr) tmo_flag <= 1'b0;
    else if (tmo_en && cond_a && hit_a) tmo_flag <= 1'b1;
  end

  // timer B: cumulative own stretching within one frame
  logic [PW-1:0] pre_b;
  logic [CW-1:0] ticks_b;
  wire           run_b = self_stretch & ~scl_in;
  wire           hit_b = ticks_b == CW'(lim_b) + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_b   <= '0;
      ticks_b <= '0;
    end else if (!ext_en || ext_clr || frame_edge) begin
      pre_b   <= '0;
      ticks_b <= '0;
    end else if (run_b && !hit_b) begin
      if (pre_b == LONG_TOP) begin
        pre_b   <= '0;
        ticks_b <= ticks_b + CW'(1);
      end else begin
        pre_b <= pre_b + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ext_flag <= 1'b0;
    else if (ext_clr) ext_flag <= 1'b0;
    else if (ext_en && !frame_edge && run_b && hit_b) ext_flag <= 1'b1;
  end

  // R7: limits and mode locked while enabled
  p_cfg_a_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_en |=> ($stable(lim_a) && $stable(idle_mode)));
  p_cfg_b_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_en |=> $stable(lim_b));
  // R8: sticky until cleared, clear wins
  p_tmo_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clr) |=> tmo_flag);
  p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_clr |=> !tmo_flag);
  p_ext_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clr |=> !ext_flag);
  // R9: no new flag while disabled
  p_tmo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_en && !tmo_flag) |=> !tmo_flag);
  p_ext_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_en && !ext_flag) |=> !ext_flag);
  // R2/R3: a timeout rises only while the monitored condition held
  p_tmo_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> ($past(idle_mode) ? ($past(scl_in) && $past(sda_in)) : !$past(scl_in)));
  // R5/R6: extension rises only during own stretching, never on a frame edge
  p_ext_cond_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_flag) |-> ($past(self_stretch) && !$past(scl_in) && !$past(frame_edge)));

endmodule

// File: tb/smbus_timeout_mon_bench.sv
`timescale 1ns/1ps
module smbus_timeout_mon_bench;
  localparam int VW = 4, LL = 4, SL = 2;
  localparam int LN = 1 << LL, SN = 1 << SL;

  logic clk = 0, rst_n = 0;
  logic scl_in = 1, sda_in = 1, self_stretch = 0, frame_edge = 0;
  logic cfg_a_wr = 0, cfg_idle_sel = 0, cfg_b_wr = 0;
  logic [VW-1:0] cfg_a_val = 0, cfg_b_val = 0;
  logic tmo_en = 0, ext_en = 0, tmo_clr = 0, ext_clr = 0;
  logic tmo_flag, ext_flag, idle_mode;
  logic [VW-1:0] lim_a, lim_b;

  smbus_timeout_mon #(.VAL_W(VW), .LONG_LOG2(LL), .SHORT_LOG2(SL)) u_smbus_timeout_mon (
    .clk, .rst_n, .scl_in, .sda_in, .self_stretch, .frame_edge,
    .cfg_a_wr, .cfg_a_val, .cfg_idle_sel, .cfg_b_wr, .cfg_b_val,
    .tmo_en, .ext_en, .tmo_clr, .ext_clr,
    .tmo_flag, .ext_flag, .lim_a, .idle_mode, .lim_b);

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int run_a = 0, acc_b = 0, m_a = 0, m_b = 0;
  bit m_idle = 0, m_tmo = 0, m_ext = 0, c_a = 0, c_b = 0;

  function automatic int limit(int v, int unit);
    return (v + 1) * unit;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      run_a = 0; acc_b = 0; m_a = 0; m_b = 0; m_idle = 0; m_tmo = 0; m_ext = 0;
    end else begin
      c_a = m_idle ? (scl_in && sda_in) : !scl_in;
      c_b = self_stretch && !scl_in;
      if (!tmo_en || tmo_clr || !c_a) run_a = 0; else run_a++;
      if (tmo_clr) m_tmo = 0;
      else if (tmo_en && c_a && run_a > limit(m_a, m_idle ? SN : LN)) m_tmo = 1;
      if (!ext_en || ext_clr || frame_edge) acc_b = 0; else if (c_b) acc_b++;
      if (ext_clr) m_ext = 0;
      else if (ext_en && !frame_edge && c_b && acc_b > limit(m_b, LN)) m_ext = 1;
      if (cfg_a_wr && !tmo_en) begin m_a = cfg_a_val; m_idle = cfg_idle_sel; end
      if (cfg_b_wr && !ext_en) m_b = cfg_b_val;
    end
  end

  // continuous comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(idle_mode ? "R3 tmo_flag" : "R2 tmo_flag", tmo_flag, m_tmo);
    chk("R5 ext_flag", ext_flag, m_ext);
    chk("R7 lim_a", lim_a, m_a);
    chk("R7 idle_mode", idle_mode, m_idle);
    chk("R7 lim_b", lim_b, m_b);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_a(int v, bit idle);
    cfg_a_val = VW'(v); cfg_idle_sel = idle; cfg_a_wr = 1; step(1); cfg_a_wr = 0;
  endtask

  task automatic wr_b(int v);
    cfg_b_val = VW'(v); cfg_b_wr = 1; step(1); cfg_b_wr = 0;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 tmo_flag", tmo_flag, 0); chk("R1 ext_flag", ext_flag, 0);
    chk("R1 lim_a", lim_a, 0); chk("R1 idle_mode", idle_mode, 0); chk("R1 lim_b", lim_b, 0);

    // R2 exact low threshold: (2+1)*16 = 48
    wr_a(2, 0);
    chk("R7 lim_a accepted", lim_a, 2);
    tmo_en = 1; scl_in = 0;
    step(48); chk("R2 no flag at 48", tmo_flag, 0);
    step(1);  chk("R2 flag at 49", tmo_flag, 1);
    wr_a(5, 1);
    chk("R7 lim_a locked", lim_a, 2); chk("R7 idle locked", idle_mode, 0);
    scl_in = 1; step(2);
    chk("R8 sticky", tmo_flag, 1);
    tmo_clr = 1; step(1); tmo_clr = 0;
    chk("R8 cleared", tmo_flag, 0);
    // R4 restart
    scl_in = 0; step(40); scl_in = 1; step(1); scl_in = 0; step(40);
    chk("R4 restart", tmo_flag, 0);
    scl_in = 1; step(1);
    // R9 disabled
    tmo_en = 0; scl_in = 0; step(100);
    chk("R9 disabled", tmo_flag, 0);
    // R3 idle threshold: (1+1)*4 = 8
    scl_in = 1; sda_in = 1;
    wr_a(1, 1);
    tmo_en = 1;
    step(8); chk("R3 no flag at 8", tmo_flag, 0);
    step(1); chk("R3 flag at 9", tmo_flag, 1);
    tmo_clr = 1; step(1); tmo_clr = 0; tmo_en = 0;

    // R5 cumulative: (1+1)*16 = 32
    wr_b(1);
    ext_en = 1;
    scl_in = 0; self_stretch = 1; step(20);
    self_stretch = 0; step(5);
    scl_in = 1; step(5);
    scl_in = 0; self_stretch = 1; step(12);
    chk("R5 no flag at 32", ext_flag, 0);
    step(1); chk("R5 flag at 33", ext_flag, 1);
    self_stretch = 0; scl_in = 1;
    ext_clr = 1; step(1); ext_clr = 0;
    chk("R8 ext cleared", ext_flag, 0);
    // R6 frame edge clears total
    scl_in = 0; self_stretch = 1; step(20);
    scl_in = 1; self_stretch = 0; frame_edge = 1; step(1); frame_edge = 0;
    scl_in = 0; self_stretch = 1; step(20);
    chk("R6 frame reset", ext_flag, 0);
    scl_in = 1; self_stretch = 0; ext_en = 0; step(2);

    // constrained random
    for (int seg = 0; seg < 160; seg++) begin
      int len;
      bit s, d, st;
      len = $urandom_range(1, 300);
      s = $urandom_range(0, 2) == 0;
      d = $urandom_range(0, 3) != 0;
      st = $urandom_range(0, 1);
      scl_in = s; sda_in = d; self_stretch = st;
      for (int i = 0; i < len; i++) begin
        tmo_clr    = $urandom_range(0, 299) == 0;
        ext_clr    = $urandom_range(0, 299) == 0;
        frame_edge = $urandom_range(0, 199) == 0;
        cfg_a_wr   = $urandom_range(0, 99) == 0;
        cfg_b_wr   = $urandom_range(0, 99) == 0;
        cfg_a_val  = VW'($urandom); cfg_b_val = VW'($urandom);
        cfg_idle_sel = $urandom_range(0, 1);
        if ($urandom_range(0, 399) == 0) tmo_en = ~tmo_en;
        if ($urandom_range(0, 399) == 0) ext_en = ~ext_en;
        if ($urandom_range(0, 49) == 0) self_stretch = ~self_stretch;
        step(1);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule